// File: doc/BRIEF.md
# ATM Cell Receive Port (Single-PHY, Cell-Level Handshake)

This block sits on the PHY side of a single-PHY, cell-level UTOPIA Level 1 link. An ATM-layer master sends 53-byte cells over a byte-wide bus. The master marks the first byte of each cell with a start-of-cell flag and qualifies each byte with an active-low enable. The block signals that it is ready through its cell-available output (CLAV). It raises CLAV only when a whole cell fits in its internal cell FIFO. It lowers CLAV in the cycle that byte 49 arrives if the cell being received will take the last free slot.

The block tracks the byte position inside each cell. If a start-of-cell appears before a cell is complete, the partial cell is thrown away and a new cell begins with that byte. Bytes that arrive outside a cell are dropped. Downstream logic reads complete cells from the read side one byte per pop. Start and end markers frame each cell. A cell becomes visible to the reader only once all 53 of its bytes are stored.

Top module: `atm_cell_rx`

## Requirements
- R1: While reset is high, `phy_clav`, `frame_err` and `cell_valid` are 0. On the first clock edge after reset is released with an empty FIFO, `phy_clav` becomes 1.
- R2: When `phy_clav` is 1 at a cell boundary (no cell in progress), the FIFO has at least one free cell slot. The capacity is CELLS cells, 4 by default.
- R3: Enable value 0 on `phy_enb_n` marks an active cycle, and the block accepts one byte on every active cycle. Cycles with `phy_enb_n` = 1 are idle, and neither store nor count a byte.
- R4: If the cell being received will fill the FIFO, `phy_clav` is 0 during the cycle in which its 49th byte is presented. It is still 1 while the 48th byte is presented.
- R5: A cell is 53 bytes long. The byte position wraps to the boundary after the 53rd accepted byte, and the cell is committed to the FIFO at that moment.
- R6: If `phy_soc` = 1 arrives on an active cycle while a cell is in progress, the partial cell is discarded and a new cell starts with that byte as its byte 0. `frame_err` is 1 for exactly the following cycle.
- R7: On an active cycle at a cell boundary, the block drops the byte and writes nothing in two cases: `phy_soc` is 0, or `phy_soc` is 1 while `phy_clav` is 0.
- R8: `cell_valid` is 1 only while at least one complete cell is stored. `cell_data` shows the oldest unread byte, and cells come out in arrival order. `cell_sop` marks byte 0 and `cell_eop` marks byte 52. `cell_pop` = 1 with `cell_valid` = 1 advances the read position by one byte at the clock edge.
- R9: When the reader pops byte 52 of a cell while no cell is being received, `phy_clav` is 1 from the next cycle on.
- R10: The value of `phy_addr` has no effect on any output.
- R11: Once a cell has started, `phy_clav` keeps its value until that cell's 48th byte has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| phy_data | input | 8 | Cell byte from the ATM layer |
| phy_soc | input | 1 | Start-of-cell flag, high with byte 0 |
| phy_enb_n | input | 1 | Active-low byte enable |
| phy_addr | input | ADDR_W | Link address, unused in single-PHY operation |
| cell_pop | input | 1 | Read side: consume the shown byte |
| phy_clav | output | 1 | Cell available: room for a whole cell |
| frame_err | output | 1 | One-cycle pulse after a mid-cell start-of-cell |
| cell_valid | output | 1 | A complete cell is readable |
| cell_data | output | 8 | Oldest unread byte |
| cell_sop | output | 1 | Shown byte is byte 0 of its cell |
| cell_eop | output | 1 | Shown byte is byte 52 of its cell |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it. An accepted byte, a restart, a commit or a pop changes `phy_clav`, `frame_err`, `cell_valid` and the read position at the next rising edge. `cell_data`, `cell_sop` and `cell_eop` then follow from the read position without any further register. The bench applies each cycle's inputs on the falling edge and advances its expected state for that edge. It compares every output at the following falling edge, so each comparison looks at the state exactly one edge after its cause. The directed checks for the 48th/49th-byte CLAV drop and for the reopening after a pop read `phy_clav` just before the relevant byte is driven. At that point the value is what the master would sample alongside that byte.

// File: rtl/atm_rx_pkg.sv
package atm_rx_pkg;

    localparam int CELL_BYTES = 53;
    localparam int IDX_W      = $clog2(CELL_BYTES);

    typedef logic [IDX_W-1:0] byte_idx_t;

    // position of the last byte of a cell
    localparam byte_idx_t LAST_IDX    = byte_idx_t'(CELL_BYTES - 1);
    // byte count reached once the 48th byte is in: CLAV is decided from here
    localparam byte_idx_t CLAV_DECIDE = byte_idx_t'(48);

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_DROP,
        ACT_START,
        ACT_RESTART
    } rx_act_e;

    typedef struct packed {
        logic      wr;
        logic      commit;
        byte_idx_t idx;
        logic [7:0] data;
    } wr_req_t;

    function automatic byte_idx_t idx_incr(byte_idx_t i);
        return (i == LAST_IDX) ? '0 : byte_idx_t'(i + 1'b1);
    endfunction

endpackage

// File: rtl/atm_rx_framer.sv
module atm_rx_framer
    import atm_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] phy_data,
    input  logic       phy_soc,
    input  logic       phy_enb_n,
    input  logic       clav,
    output wr_req_t    wr,
    output byte_idx_t  cnt_q,
    output byte_idx_t  cnt_next,
    output logic       err_q
);

    rx_act_e act;
    logic    in_cell;
    logic    cont;

    assign in_cell = (cnt_q != '0);

    // classify the current cycle
    always_comb begin
        act  = ACT_IDLE;
        cont = 1'b0;
        if (!phy_enb_n) begin
            if (phy_soc) begin
                if (in_cell)      act = ACT_RESTART;
                else if (clav)    act = ACT_START;
                else              act = ACT_DROP;
            end else if (in_cell) begin
                cont = 1'b1;
            end else begin
                act = ACT_DROP;
            end
        end
    end

    always_comb begin
        wr       = '0;
        wr.data  = phy_data;
        cnt_next = cnt_q;
        case (act)
            ACT_START, ACT_RESTART: begin
                wr.wr    = 1'b1;
                wr.idx   = '0;
                cnt_next = byte_idx_t'(1);
            end
            default: begin
                if (cont) begin
                    wr.wr     = 1'b1;
                    wr.idx    = cnt_q;
                    wr.commit = (cnt_q == LAST_IDX);
                    cnt_next  = idx_incr(cnt_q);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            cnt_q <= cnt_next;
            err_q <= (act == ACT_RESTART);
        end
    end

endmodule

// File: rtl/atm_cell_buffer.sv
module atm_cell_buffer
    import atm_rx_pkg::*;
#(
    parameter int CELLS = 4,
    localparam int CW   = $clog2(CELLS + 1),
    localparam int SW   = (CELLS > 1) ? $clog2(CELLS) : 1
)(
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       wr,
    input  logic          pop,
    output logic          valid,
    output logic [7:0]    rd_data,
    output logic          rd_sop,
    output logic          rd_eop,
    output logic [CW-1:0] cells_q,
    output logic [CW-1:0] cells_next
);

    localparam int DEPTH = CELLS * CELL_BYTES;
    localparam int AW    = $clog2(DEPTH);

    function automatic logic [SW-1:0] slot_incr(logic [SW-1:0] s);
        return (s == SW'(CELLS - 1)) ? '0 : SW'(s + 1'b1);
    endfunction

    logic [7:0]    mem [DEPTH];
    logic [SW-1:0] wr_slot, rd_slot;
    byte_idx_t     rd_idx;
    logic [AW-1:0] waddr, raddr;
    logic          pop_ok, free;

    // partial cells stay inside wr_slot until committed, so a restart needs no rewind
    assign waddr = AW'(AW'(wr_slot) * AW'(CELL_BYTES)) + AW'(wr.idx);
    assign raddr = AW'(AW'(rd_slot) * AW'(CELL_BYTES)) + AW'(rd_idx);

    assign valid   = (cells_q != '0);
    assign rd_data = mem[raddr];
    assign rd_sop  = (rd_idx == '0);
    assign rd_eop  = (rd_idx == LAST_IDX);

    assign pop_ok     = pop && valid;
    assign free       = pop_ok && rd_eop;
    assign cells_next = cells_q + CW'(wr.commit) - CW'(free);

    always_ff @(posedge clk) begin
        if (wr.wr) mem[waddr] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_slot <= '0;
            rd_slot <= '0;
            rd_idx  <= '0;
            cells_q <= '0;
        end else begin
            cells_q <= cells_next;
            if (wr.commit) wr_slot <= slot_incr(wr_slot);
            if (pop_ok) begin
                rd_idx <= idx_incr(rd_idx);
                if (free) rd_slot <= slot_incr(rd_slot);
            end
        end
    end

endmodule

// File: rtl/atm_clav_ctrl.sv
module atm_clav_ctrl
    import atm_rx_pkg::*;
#(
    parameter int CELLS = 4,
    localparam int CW   = $clog2(CELLS + 1)
)(
    input  logic          clk,
    input  logic          rst,
    input  byte_idx_t     cnt_next,
    input  logic [CW-1:0] cells_next,
    output logic          clav_q
);

    logic [CW:0] used;
    logic        decide;
    logic        room;

    // slots taken after this edge: complete cells plus a cell in progress
    assign used   = {1'b0, cells_next} + (CW + 1)'(cnt_next != '0);
    assign room   = (used < (CW + 1)'(CELLS));
    assign decide = (cnt_next == '0) || (cnt_next >= CLAV_DECIDE);

    always_ff @(posedge clk) begin
        if (rst)         clav_q <= 1'b0;
        else if (decide) clav_q <= room;
    end

endmodule

// File: rtl/atm_cell_rx.sv
module atm_cell_rx
    import atm_rx_pkg::*;
#(
    parameter int CELLS  = 4,
    parameter int ADDR_W = 5,
    localparam int CW    = $clog2(CELLS + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        phy_data,
    input  logic              phy_soc,
    input  logic              phy_enb_n,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              cell_pop,
    output logic              phy_clav,
    output logic              frame_err,
    output logic              cell_valid,
    output logic [7:0]        cell_data,
    output logic              cell_sop,
    output logic              cell_eop
);

    wr_req_t       wr;
    byte_idx_t     rx_cnt, rx_cnt_next;
    logic [CW-1:0] fifo_cells, fifo_cells_next;
    logic          unused_addr;

    // single-PHY link: the address carries no meaning here
    assign unused_addr = ^phy_addr;

    atm_rx_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .phy_data  (phy_data),
        .phy_soc   (phy_soc),
        .phy_enb_n (phy_enb_n),
        .clav      (phy_clav),
        .wr        (wr),
        .cnt_q     (rx_cnt),
        .cnt_next  (rx_cnt_next),
        .err_q     (frame_err)
    );

    atm_cell_buffer #(.CELLS(CELLS)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .pop        (cell_pop),
        .valid      (cell_valid),
        .rd_data    (cell_data),
        .rd_sop     (cell_sop),
        .rd_eop     (cell_eop),
        .cells_q    (fifo_cells),
        .cells_next (fifo_cells_next)
    );

    atm_clav_ctrl #(.CELLS(CELLS)) u_clav (
        .clk        (clk),
        .rst        (rst),
        .cnt_next   (rx_cnt_next),
        .cells_next (fifo_cells_next),
        .clav_q     (phy_clav)
    );

endmodule

// File: rtl/atm_cell_rx_chk.sv
module atm_cell_rx_chk
    import atm_rx_pkg::*;
#(
    parameter int CELLS = 4,
    localparam int CW   = $clog2(CELLS + 1)
)(
    input logic          clk,
    input logic          rst,
    input logic          phy_clav,
    input logic          phy_soc,
    input logic          phy_enb_n,
    input logic          frame_err,
    input byte_idx_t     rx_cnt,
    input logic [CW-1:0] fifo_cells
);

    // R2
    clav_room_chk: assert property (@(posedge clk) disable iff (rst)
        (phy_clav && rx_cnt == '0) |-> (fifo_cells < CW'(CELLS)));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_cells <= CW'(CELLS));

    // R11
    clav_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt != '0 && rx_cnt < CLAV_DECIDE) |-> $stable(phy_clav));

    // R4
    clav_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(phy_clav) |-> (rx_cnt == CLAV_DECIDE));

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $past(!phy_enb_n && phy_soc && rx_cnt != '0));

endmodule

bind atm_cell_rx atm_cell_rx_chk #(.CELLS(CELLS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .phy_clav   (phy_clav),
    .phy_soc    (phy_soc),
    .phy_enb_n  (phy_enb_n),
    .frame_err  (frame_err),
    .rx_cnt     (rx_cnt),
    .fifo_cells (fifo_cells)
);

// File: tb/tb_atm_cell_rx.sv
`timescale 1ns/1ps
module tb_atm_cell_rx;

    localparam int NCELL = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] phy_data;
    logic       phy_soc, phy_enb_n, cell_pop;
    logic [4:0] phy_addr;
    logic       phy_clav, frame_err, cell_valid, cell_sop, cell_eop;
    logic [7:0] cell_data;

    always #2 clk = ~clk;

    atm_cell_rx dut (
        .clk(clk), .rst(rst), .phy_data(phy_data), .phy_soc(phy_soc),
        .phy_enb_n(phy_enb_n), .phy_addr(phy_addr), .cell_pop(cell_pop),
        .phy_clav(phy_clav), .frame_err(frame_err), .cell_valid(cell_valid),
        .cell_data(cell_data), .cell_sop(cell_sop), .cell_eop(cell_eop)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state
    int   m_cnt, m_cells, m_rd;
    bit   m_clav, m_err;
    byte unsigned exp_q[$];
    byte unsigned cur[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(phy_clav == m_clav, "R4 clav", phy_clav, m_clav);
        chk(frame_err == m_err, "R6 frame_err", frame_err, m_err);
        chk(cell_valid == (m_cells > 0), "R8 valid", cell_valid, m_cells > 0);
        if (m_cells > 0 && exp_q.size() > 0) begin
            chk(cell_data == exp_q[0], "R8 data", cell_data, exp_q[0]);
            chk(cell_sop == (m_rd == 0), "R8 sop", cell_sop, m_rd == 0);
            chk(cell_eop == (m_rd == 52), "R5 eop", cell_eop, m_rd == 52);
        end
    endtask

    // one clock: model the edge, drive, then compare after the edge
    task automatic step(input bit enb_n, input bit soc, input byte unsigned d, input bit rd);
        bit pop, freed, commit;
        int n_cnt, n_cells, used;
        pop = rd && (m_cells > 0);
        freed = pop && (m_rd == 52);
        commit = 0;
        n_cnt = m_cnt;
        m_err = 0;
        if (!enb_n) begin
            if (soc) begin
                if (m_cnt != 0) begin
                    m_err = 1; cur.delete(); cur.push_back(d); n_cnt = 1;
                end else if (m_clav) begin
                    cur.delete(); cur.push_back(d); n_cnt = 1;
                end
            end else if (m_cnt != 0) begin
                cur.push_back(d);
                if (m_cnt == 52) begin commit = 1; n_cnt = 0; end
                else n_cnt = m_cnt + 1;
            end
        end
        if (pop) begin
            void'(exp_q.pop_front());
            m_rd = (m_rd == 52) ? 0 : m_rd + 1;
        end
        if (commit) begin
            foreach (cur[i]) exp_q.push_back(cur[i]);
            cur.delete();
        end
        n_cells = m_cells + int'(commit) - int'(freed);
        used = n_cells + ((n_cnt != 0) ? 1 : 0);
        if (n_cnt == 0 || n_cnt >= 48) m_clav = (used < NCELL);
        m_cnt = n_cnt;
        m_cells = n_cells;
        phy_enb_n = enb_n;
        phy_soc = soc;
        phy_data = d;
        phy_addr = 5'($urandom);  // R10: address randomised, model ignores it
        cell_pop = rd;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic send_cell(input byte unsigned base, input bit watch, input int rdpct);
        for (int i = 0; i < 53; i++) begin
            if (watch && i == 47) chk(phy_clav == 1, "R4 clav at byte 48", phy_clav, 1);
            if (watch && i == 48) chk(phy_clav == 0, "R4 clav at byte 49", phy_clav, 0);
            step(1'b0, i == 0, byte'(base + i), ($urandom % 100) < rdpct);
        end
    endtask

    task automatic drain(output int pops);
        pops = 0;
        while (cell_valid && pops < 1000) begin
            step(1'b1, 1'b0, 8'h00, 1'b1);
            pops++;
        end
    endtask

    initial begin
        int pops;
        int pos;
        int rdpct;
        void'($urandom(32'd1234));
        rst = 1'b1; phy_enb_n = 1'b1; phy_soc = 1'b0; phy_data = '0;
        phy_addr = '0; cell_pop = 1'b0;
        m_cnt = 0; m_cells = 0; m_rd = 0; m_clav = 0; m_err = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(phy_clav == 0, "R1 clav in reset", phy_clav, 0);
        chk(frame_err == 0, "R1 err in reset", frame_err, 0);
        chk(cell_valid == 0, "R1 valid in reset", cell_valid, 0);
        rst = 1'b0;
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk(phy_clav == 1, "R1 clav after reset", phy_clav, 1);

        // fill the FIFO without reads, idle gaps in between (R3)
        send_cell(8'h10, 0, 0);
        repeat (3) step(1'b1, 1'b0, 8'hEE, 1'b0);
        send_cell(8'h40, 0, 0);
        send_cell(8'h70, 0, 0);
        send_cell(8'hA0, 1, 0);
        chk(phy_clav == 0, "R2 clav full", phy_clav, 0);
        // R7: a cell offered while CLAV is low is dropped
        send_cell(8'hD0, 0, 0);
        chk(cell_valid == 1, "R8 valid full", cell_valid, 1);
        for (int i = 0; i < 53; i++) step(1'b1, 1'b0, 8'h00, 1'b1);
        chk(phy_clav == 1, "R9 clav reopens after pop", phy_clav, 1);
        drain(pops);
        chk(pops == 3 * 53, "R7 refused cell not stored", pops, 3 * 53);

        // R6 restart in the middle of a cell
        for (int i = 0; i < 10; i++) step(1'b0, i == 0, byte'(8'h20 + i), 1'b0);
        step(1'b0, 1'b1, 8'h55, 1'b0);
        chk(frame_err == 1, "R6 error pulse", frame_err, 1);
        for (int i = 1; i < 53; i++) step(1'b0, 1'b0, byte'(8'h55 + i), 1'b0);
        chk(frame_err == 0, "R6 pulse length", frame_err, 0);
        drain(pops);
        chk(pops == 53, "R6 one cell after restart", pops, 53);

        // R7 stray bytes at a boundary
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 8'h99, 1'b0);
        chk(cell_valid == 0, "R7 stray dropped", cell_valid, 0);
        send_cell(8'h01, 0, 30);
        drain(pops);
        chk(m_cells == 0 && cell_valid == 0, "R5 drained", cell_valid, 0);

        // constrained random traffic
        pos = 0;
        rdpct = 50;
        for (int c = 0; c < 6000; c++) begin
            bit en, soc;
            if (c % 700 == 0) rdpct = (rdpct == 50) ? 5 : 50;
            en = ($urandom % 100) < 70;
            soc = 0;
            if (en) begin
                if (pos == 0) soc = ($urandom % 100) >= 3;
                else if (($urandom % 100) < 2) begin soc = 1; pos = 0; end
                if (soc || pos != 0) pos = (pos == 52) ? 0 : pos + 1;
            end
            step(!en, soc, byte'($urandom), ($urandom % 100) < rdpct);
        end
        drain(pops);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule